// File: doc/BRIEF.md
# Pessimistic Status-Channel Credit Tracker

This block sits on the transmit side of a packet interface. It listens to the out-of-band FIFO status channel sent back by the link partner. That channel repeats a short calendar, and each calendar cycle carries a two-bit fill report for every port in the calendar. The block parses each cycle and checks it against a two-bit diagonal parity word. It then turns the accepted reports into per-port transmit credits, counted in 16-byte segments, for the burst framer. The framer spends one credit for each segment it sends.

The policy is deliberately pessimistic. When a parity word is wrong, every port loses its whole credit at once and every port is reported as full. Nothing is granted again until a complete, correctly checked status cycle has been received. A burst that the framer has already started is not interrupted by the block; the framer finishes it, and its decrements simply floor at zero. The status channel is treated as a per-cycle enable, so the status clock itself is outside the block.

Top module: `fifo_stat_credit`

## Requirements
- R1: After reset every credit is 0, every port status reads SATISFIED (2'b10), and `cycle_ok_o` and `dip_err_o` are low.
- R2: Only words with `stat_en_i` high are used. The code 2'b11 starts a status cycle. The next N words are the status codes for ports 0..N-1 in order, where N is `cal_len_i`, or the port count when `cal_len_i` is 0 or too large. The word after them is the parity word.
- R3: The parity is computed as follows. A 2-bit accumulator starts at 2'b11. For each status word w, the accumulator becomes {acc[0], acc[1]} XOR w. The cycle is clean when the parity word equals the final accumulator.
- R4: On a clean cycle, each calendar port's credit is replaced, not added to. Code 2'b00 (STARVING) sets it to `mb1_i`, 2'b01 (HUNGRY) sets it to `mb2_i`, and 2'b10 (SATISFIED) sets it to 0. The port status output takes the code. `cycle_ok_o` pulses one cycle. All of this is visible the cycle after the parity word is taken.
- R5: A clean cycle leaves the credit and status of ports at or above N unchanged.
- R6: On a parity mismatch, all credits become 0, all statuses become SATISFIED, and `dip_err_o` pulses. This is visible the cycle after the parity word is taken.
- R7: After a mismatch, no credit is granted until a complete clean cycle arrives. Partial cycles and further bad cycles grant nothing.
- R8: `take_vld_i` decrements the credit of port `take_port_i` by one. A credit of 0 stays at 0. A port index at or above the port count has no effect.
- R9: When a decrement lands in the same cycle as a clean parity word for a calendar port, the new grant wins. When it lands in the same cycle as a mismatch, the zeroing wins.
- R10: A 2'b11 received in a status slot abandons the cycle in progress and starts a new one. There is no grant and no error.
- R11: Words with `stat_en_i` low change nothing in the parser, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stat_en_i | input | 1 | Status word valid |
| stat_i | input | 2 | Status channel word |
| cal_len_i | input | CALW (4) | Number of ports in the calendar |
| mb1_i | input | CW (8) | Grant in segments for STARVING |
| mb2_i | input | CW (8) | Grant in segments for HUNGRY |
| take_vld_i | input | 1 | Framer sent one 16-byte segment |
| take_port_i | input | PW (4) | Port of that segment |
| credit_o | output | NPORTS*CW (80) | Per-port credits, port i at bits [i*CW +: CW] |
| pstat_o | output | NPORTS*2 (20) | Per-port accepted status, port i at bits [2i +: 2] |
| cycle_ok_o | output | 1 | Pulse: clean status cycle committed |
| dip_err_o | output | 1 | Pulse: parity mismatch, all credit withdrawn |

## Verification
The stimulus covers clean cycles with mixed codes across a full calendar, and repeated STARVING reports that would expose accumulation. Cycles with the low parity bit flipped and with the high parity bit flipped show whether the check covers both bits. Cycles sent with idle gaps filled with 2'b11 separate a correct enable qualifier from a parser that reacts to every word. An aborted partial cycle followed by a full one, and a shortened calendar, separate restart handling and slot masking from the main grant path. Decrements placed exactly on the parity word, on zero credits and on an out-of-range port expose the priority order and the floor.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    localparam logic [1:0] CODE_STARVE = 2'b00;
    localparam logic [1:0] CODE_HUNGRY = 2'b01;
    localparam logic [1:0] CODE_SATIS  = 2'b10;
    localparam logic [1:0] CODE_FRAME  = 2'b11;
    localparam logic [1:0] DIP_SEED    = 2'b11;

    typedef enum logic {PH_HUNT, PH_COLLECT} phase_e;

    // one step of the diagonal parity: swap the bits, then fold in the word
    function automatic logic [1:0] dip_step(input logic [1:0] acc, input logic [1:0] w);
        return {acc[0], acc[1]} ^ w;
    endfunction
endpackage

// File: rtl/fsc_stat_rx.sv
module fsc_stat_rx
    import fsc_pkg::*;
#(
    parameter int NPORTS = 10,
    parameter int CALW   = $clog2(NPORTS + 1),
    parameter int PW     = $clog2(NPORTS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stat_en_i,
    input  logic [1:0]             stat_i,
    input  logic [CALW-1:0]        cal_len_i,
    output logic                   commit_o,
    output logic                   err_o,
    output logic [NPORTS-1:0][1:0] shadow_o,
    output logic [NPORTS-1:0]      upd_o
);
    typedef struct packed {
        phase_e                   phase;
        logic [CALW-1:0]          slot;
        logic [1:0]               acc;
        logic [NPORTS-1:0][1:0]   shadow;
    } rx_s;

    localparam logic [CALW-1:0] FULL_CAL = CALW'(NPORTS);

    rx_s q, d;
    logic [CALW-1:0] cal_eff;
    logic [PW-1:0]   sidx;

    always_comb begin
        d        = q;
        commit_o = 1'b0;
        err_o    = 1'b0;
        cal_eff  = (cal_len_i == '0 || cal_len_i > FULL_CAL) ? FULL_CAL : cal_len_i;
        sidx     = q.slot[PW-1:0];
        if (stat_en_i) begin
            unique case (q.phase)
                PH_HUNT: begin
                    if (stat_i == CODE_FRAME) begin
                        d.phase = PH_COLLECT;
                        d.slot  = '0;
                        d.acc   = DIP_SEED;
                    end
                end
                PH_COLLECT: begin
                    if (q.slot < cal_eff) begin
                        if (stat_i == CODE_FRAME) begin
                            d.slot = '0;
                            d.acc  = DIP_SEED;
                        end else begin
                            d.shadow[sidx] = stat_i;
                            d.acc          = dip_step(q.acc, stat_i);
                            d.slot         = q.slot + 1'b1;
                        end
                    end else begin
                        if (stat_i == q.acc) commit_o = 1'b1;
                        else                 err_o    = 1'b1;
                        d.phase = PH_HUNT;
                        d.slot  = '0;
                    end
                end
                default: d.phase = PH_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.phase  <= PH_HUNT;
            q.slot   <= '0;
            q.acc    <= DIP_SEED;
            q.shadow <= {NPORTS{CODE_SATIS}};
        end else begin
            q <= d;
        end
    end

    assign shadow_o = q.shadow;

    for (genvar g = 0; g < NPORTS; g++) begin : g_mask
        assign upd_o[g] = (CALW'(g) < cal_eff);
    end

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit_o && err_o));
    p_slot_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.slot <= FULL_CAL);
    p_hunt_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_HUNT) |-> !(commit_o || err_o));
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_en_i |=> $stable(q));
endmodule

// File: rtl/fsc_credit_bank.sv
module fsc_credit_bank
    import fsc_pkg::*;
#(
    parameter int NPORTS = 10,
    parameter int CW     = 8,
    parameter int PW     = $clog2(NPORTS)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    commit_i,
    input  logic                    err_i,
    input  logic [NPORTS-1:0][1:0]  shadow_i,
    input  logic [NPORTS-1:0]       upd_i,
    input  logic [CW-1:0]           mb1_i,
    input  logic [CW-1:0]           mb2_i,
    input  logic                    take_vld_i,
    input  logic [PW-1:0]           take_port_i,
    output logic [NPORTS-1:0][CW-1:0] cred_o,
    output logic [NPORTS-1:0][1:0]  st_o,
    output logic                    ok_o,
    output logic                    err_o
);
    typedef struct packed {
        logic [NPORTS-1:0][CW-1:0] cred;
        logic [NPORTS-1:0][1:0]    st;
        logic                      ok;
        logic                      err;
    } bank_s;

    bank_s q, d;

    always_comb begin
        d     = q;
        d.ok  = commit_i;
        d.err = err_i;
        for (int i = 0; i < NPORTS; i++) begin
            if (err_i) begin
                d.cred[i] = '0;
                d.st[i]   = CODE_SATIS;
            end else if (commit_i && upd_i[i]) begin
                d.st[i] = shadow_i[i];
                unique case (shadow_i[i])
                    CODE_STARVE: d.cred[i] = mb1_i;
                    CODE_HUNGRY: d.cred[i] = mb2_i;
                    default:     d.cred[i] = '0;
                endcase
            end else if (take_vld_i && take_port_i == PW'(i) && q.cred[i] != '0) begin
                d.cred[i] = q.cred[i] - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.cred <= '0;
            q.st   <= {NPORTS{CODE_SATIS}};
            q.ok   <= 1'b0;
            q.err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cred_o = q.cred;
    assign st_o   = q.st;
    assign ok_o   = q.ok;
    assign err_o  = q.err;

    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_i |=> (q.cred == '0 && q.st == {NPORTS{CODE_SATIS}}));

    for (genvar g = 0; g < NPORTS; g++) begin : g_chk
        p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!commit_i && !err_i) |=>
            (q.cred[g] == $past(q.cred[g]) || q.cred[g] == $past(q.cred[g]) - 1'b1));
        p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!commit_i && !err_i && !take_vld_i) |=> $stable(q.cred[g]));
    end
endmodule

// File: rtl/fifo_stat_credit.sv
module fifo_stat_credit #(
    parameter int NPORTS = 10,
    parameter int CW     = 8,
    parameter int CALW   = $clog2(NPORTS + 1),
    parameter int PW     = $clog2(NPORTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stat_en_i,
    input  logic [1:0]           stat_i,
    input  logic [CALW-1:0]      cal_len_i,
    input  logic [CW-1:0]        mb1_i,
    input  logic [CW-1:0]        mb2_i,
    input  logic                 take_vld_i,
    input  logic [PW-1:0]        take_port_i,
    output logic [NPORTS*CW-1:0] credit_o,
    output logic [NPORTS*2-1:0]  pstat_o,
    output logic                 cycle_ok_o,
    output logic                 dip_err_o
);
    logic                      commit, err;
    logic [NPORTS-1:0][1:0]    shadow;
    logic [NPORTS-1:0]         upd;
    logic [NPORTS-1:0][CW-1:0] cred;
    logic [NPORTS-1:0][1:0]    st;

    fsc_stat_rx #(.NPORTS(NPORTS), .CALW(CALW), .PW(PW)) i_rx (
        .clk(clk), .rst_n(rst_n), .stat_en_i(stat_en_i), .stat_i(stat_i),
        .cal_len_i(cal_len_i), .commit_o(commit), .err_o(err),
        .shadow_o(shadow), .upd_o(upd)
    );

    fsc_credit_bank #(.NPORTS(NPORTS), .CW(CW), .PW(PW)) i_bank (
        .clk(clk), .rst_n(rst_n), .commit_i(commit), .err_i(err),
        .shadow_i(shadow), .upd_i(upd), .mb1_i(mb1_i), .mb2_i(mb2_i),
        .take_vld_i(take_vld_i), .take_port_i(take_port_i),
        .cred_o(cred), .st_o(st), .ok_o(cycle_ok_o), .err_o(dip_err_o)
    );

    for (genvar g = 0; g < NPORTS; g++) begin : g_flat
        assign credit_o[g*CW +: CW] = cred[g];
        assign pstat_o[g*2 +: 2]    = st[g];
    end

    p_pulse_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(cycle_ok_o && dip_err_o));
endmodule

// File: tb/test_fifo_stat_credit.sv
module test_fifo_stat_credit;
    localparam int N  = 10;
    localparam int CW = 8;
    localparam logic [7:0] MB1 = 8'd9;
    localparam logic [7:0] MB2 = 8'd3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic stat_en_i = 1'b0;
    logic [1:0] stat_i = 2'b00;
    logic [3:0] cal_len_i = 4'd10;
    logic [7:0] mb1_i = MB1, mb2_i = MB2;
    logic take_vld_i = 1'b0;
    logic [3:0] take_port_i = '0;
    logic [N*CW-1:0] credit_o;
    logic [N*2-1:0]  pstat_o;
    logic cycle_ok_o, dip_err_o;

    always #10 clk = ~clk;

    fifo_stat_credit i_fifo_stat_credit (.*);

    typedef struct {
        bit              is_err;
        logic [N*CW-1:0] cred;
        logic [N*2-1:0]  st;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int   mcred[N];
    logic [1:0] mst[N];
    int   n_chk = 0, n_bad = 0;
    bit   finished = 0;

    function automatic logic [N*CW-1:0] flat_cred();
        logic [N*CW-1:0] v;
        for (int i = 0; i < N; i++) v[i*CW +: CW] = CW'(mcred[i]);
        return v;
    endfunction

    function automatic logic [N*2-1:0] flat_st();
        logic [N*2-1:0] v;
        for (int i = 0; i < N; i++) v[i*2 +: 2] = mst[i];
        return v;
    endfunction

    task automatic check_all(input string tag);
        n_chk++;
        if (credit_o !== flat_cred() || pstat_o !== flat_st()) begin
            n_bad++;
            $display("FAIL %s cred=%h/st=%h expected cred=%h/st=%h",
                     tag, credit_o, pstat_o, flat_cred(), flat_st());
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (cycle_ok_o || dip_err_o)) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R7 unexpected event ok=%b err=%b expected none", cycle_ok_o, dip_err_o);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (cycle_ok_o !== !e.is_err || dip_err_o !== e.is_err ||
                    credit_o !== e.cred || pstat_o !== e.st) begin
                    n_bad++;
                    $display("FAIL %s ok=%b err=%b cred=%h st=%h expected err=%b cred=%h st=%h",
                             e.tag, cycle_ok_o, dip_err_o, credit_o, pstat_o, e.is_err, e.cred, e.st);
                end
            end
        end
    end

    task automatic drive(input logic [1:0] w, input bit gaps, input int tport);
        @(negedge clk);
        stat_en_i   = 1'b1;
        stat_i      = w;
        take_vld_i  = (tport >= 0);
        take_port_i = 4'(tport < 0 ? 0 : tport);
        if (gaps) begin
            @(negedge clk);
            stat_en_i  = 1'b0;
            stat_i     = 2'b11;   // framing value, must be ignored
            take_vld_i = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            stat_en_i = 1'b0; stat_i = 2'b00; take_vld_i = 1'b0;
        end
    endtask

    // sv: codes for ports 0..n-1; flip: xor on the parity word; tport: decrement on parity word
    task automatic send_cycle(input logic [N*2-1:0] sv, input int n, input logic [1:0] flip,
                              input int tport, input bit gaps, input string tag);
        logic [1:0] acc;
        exp_t e;
        acc = 2'b11;
        drive(2'b11, gaps, -1);
        for (int i = 0; i < n; i++) begin
            drive(sv[i*2 +: 2], gaps, -1);
            acc = {acc[0], acc[1]} ^ sv[i*2 +: 2];
        end
        if (flip != 2'b00) begin
            for (int i = 0; i < N; i++) begin mcred[i] = 0; mst[i] = 2'b10; end
            e.is_err = 1;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (i < n) begin
                    mst[i] = sv[i*2 +: 2];
                    mcred[i] = (mst[i] == 2'b00) ? int'(MB1) : (mst[i] == 2'b01) ? int'(MB2) : 0;
                end else if (i == tport && mcred[i] > 0) begin
                    mcred[i]--;
                end
            end
            e.is_err = 0;
        end
        e.cred = flat_cred();
        e.st   = flat_st();
        e.tag  = tag;
        exp_q.push_back(e);
        drive(acc ^ flip, gaps, tport);
        idle(2);
    endtask

    task automatic take(input int port);
        @(negedge clk);
        take_vld_i = 1'b1; take_port_i = 4'(port);
        if (port < N && mcred[port] > 0) mcred[port]--;
        @(negedge clk);
        take_vld_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin mcred[i] = 0; mst[i] = 2'b10; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_all("R1 reset credits/status");
        n_chk++;
        if (cycle_ok_o !== 1'b0 || dip_err_o !== 1'b0) begin
            n_bad++; $display("FAIL R1 pulses ok=%b err=%b expected 0 0", cycle_ok_o, dip_err_o);
        end

        // R2 R3 R4: mixed codes, full calendar
        send_cycle({2'b10,2'b01,2'b00,2'b00,2'b01,2'b10,2'b01,2'b00,2'b10,2'b00}, N, 2'b00, -1, 0, "R4 mixed grant");
        check_all("R3 clean parity accepted");
        // R8: decrements, floor at zero, out-of-range port
        take(0); take(0); take(2);
        check_all("R8 decrement");
        take(1); take(1);            // port 1 SATISFIED -> zero stays zero
        take(12);
        check_all("R8 floor and out-of-range");
        // R4: replace, no accumulation
        send_cycle({N{2'b00}}, N, 2'b00, -1, 0, "R4 replace not add");
        send_cycle({N{2'b00}}, N, 2'b00, -1, 0, "R4 no accumulate");
        // R11: gaps carrying 2'b11 with enable low
        send_cycle({2'b01,2'b00,2'b01,2'b00,2'b01,2'b00,2'b01,2'b00,2'b01,2'b00}, N, 2'b00, -1, 1, "R11 gapped cycle");
        // R9: decrement on parity word for calendar port -> grant wins
        send_cycle({N{2'b01}}, N, 2'b00, 3, 0, "R9 grant beats take");
        // R5: short calendar, ports 4..9 untouched
        cal_len_i = 4'd4;
        take(6); take(9);
        send_cycle({12'h000, 2'b10,2'b00,2'b10,2'b00}, 4, 2'b00, 7, 0, "R5 short calendar");
        check_all("R5 upper ports kept");
        // R6: low bit flipped
        send_cycle({12'h000, 2'b00,2'b00,2'b00,2'b00}, 4, 2'b01, -1, 0, "R6 parity bit0 error");
        check_all("R6 all withdrawn");
        cal_len_i = 4'd10;
        // R7: partial cycle grants nothing
        drive(2'b11, 0, -1); drive(2'b00, 0, -1); drive(2'b00, 0, -1);
        idle(4);
        take(2);
        check_all("R7 partial cycle no grant");
        // R10: restart on framing mid-cycle, then a proper cycle
        drive(2'b11, 0, -1); drive(2'b01, 0, -1); drive(2'b00, 0, -1);
        send_cycle({2'b00,2'b01,2'b10,2'b00,2'b01,2'b10,2'b00,2'b01,2'b10,2'b00}, N, 2'b00, -1, 0, "R10 restart then clean");
        // R6 R9: high bit flipped with decrement on parity word
        send_cycle({N{2'b00}}, N, 2'b10, 0, 0, "R9 error beats take");
        // R7: another bad cycle, still nothing
        send_cycle({N{2'b01}}, N, 2'b11, -1, 0, "R7 repeated error");
        check_all("R7 still withdrawn");
        send_cycle({N{2'b01}}, N, 2'b00, -1, 0, "R7 regrant after clean");
        check_all("R4 final state");
        idle(3);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_bad++; $display("FAIL R4 missing events left=%0d expected 0", exp_q.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog expired expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule